// File: doc/BRIEF.md
# UART FIFO Trigger Level Controller

This block sets the fill thresholds for the receive and transmit FIFOs of one UART channel. It also raises the two interrupt requests that follow from those thresholds. A byte-wide write port reaches four control registers. The first is the FIFO control byte, which holds the RX and TX trigger codes and the DMA mode bit. The second is a feature byte, which holds the table select and the direction for programmable writes. The third is an unlock byte that gates the TX code bits. The fourth is a programmable trigger value. One table select covers both directions. It picks one of three fixed trigger tables or a pair of programmable levels.

The FIFO storage sits outside the block. The block receives the live RX and TX fill counts from it, together with pulses for a TX FIFO write (load) and an interrupt acknowledge. It registers the active levels and the interrupt requests. The TX request follows a two-rule scheme. When the FIFO was last filled above the threshold, the request fires as the count drops below the threshold. Otherwise it waits until the FIFO is empty.

Top module: `uart_fifo_trig_ctrl`

## Requirements
- R1: After a synchronous reset, both level outputs read 1, both interrupt requests and dma_mode read 0, all registers are zero and the programmable levels are 1.
- R2: Table select 00 (feature byte bits 5:4) gives RX levels 1, 4, 8, 14 for RX code 0..3 (FIFO control bits 7:6), and a fixed TX level of 1.
- R3: Table select 01 gives RX levels 8, 16, 24, 28 for RX codes 0..3, and TX levels 16, 8, 24, 30 for TX codes 0..3 (FIFO control bits 5:4).
- R4: Table select 10 gives RX levels 8, 16, 56, 60 and TX levels 8, 16, 32, 56 for codes 0..3.
- R5: Table select 11 uses the programmable levels. A write to the trigger register (wr_sel 3) loads the RX level when feature byte bit 7 is 0 and the TX level when that bit is 1.
- R6: A programmable trigger write of 0 is stored as 1. A value above DEPTH is stored as DEPTH.
- R7: A write to the FIFO control byte changes the TX code only while unlock register bit 4 is 1. Otherwise the TX code keeps its old value, and the other fields of the byte are still written.
- R8: rx_irq equals (rx_count >= active RX level) as sampled on the previous clock edge, so it drops one cycle after the count falls below the level.
- R9: Once tx_count has exceeded the active TX level since the FIFO was last empty, tx_irq sets one cycle after tx_count first goes below that level.
- R10: When tx_count has not exceeded the level since the FIFO was last empty, tx_irq sets only one cycle after tx_count becomes 0. Neither rule sets the request again while its condition simply persists, and a condition already true at reset does not set it.
- R11: tx_irq clears in the cycle after tx_ack or tx_load, and this clear wins over a set in the same cycle.
- R12: dma_mode follows FIFO control bit 3 one cycle after the write.
- R13: Level outputs are registered. A register write shows on rx_level or tx_level two cycles after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 FIFO control, 1 feature, 2 unlock, 3 trigger value |
| wr_data | input | 8 | Write data |
| rx_count | input | CNT_W | RX FIFO fill count |
| tx_count | input | CNT_W | TX FIFO fill count |
| tx_load | input | 1 | A character is being written into the TX FIFO |
| tx_ack | input | 1 | TX interrupt acknowledge |
| rx_level | output | CNT_W | Active RX trigger level |
| tx_level | output | CNT_W | Active TX trigger level |
| rx_irq | output | 1 | RX data interrupt request |
| tx_irq | output | 1 | TX threshold/empty interrupt request |
| dma_mode | output | 1 | Stored DMA mode bit |

## Verification
The bench uses the default DEPTH of 128, which gives CNT_W = 8. With that setting the full span of fill counts, including a completely full FIFO, can be driven. Trigger writes of 0, 128 and values up to 255 are also in range, so the clamp at both ends is reachable. The random phase runs through every table and code, with the unlock bit set and cleared. It moves the TX count in steps wide enough to cross the threshold both from above and from below, and to reach empty with or without a prior overfill.

// File: rtl/uart_trig_pkg.sv
package uart_trig_pkg;

  typedef enum logic [1:0] {
    SEL_FIFO_CTRL = 2'd0,
    SEL_FEATURE   = 2'd1,
    SEL_UNLOCK    = 2'd2,
    SEL_TRIGGER   = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    TBL_LEGACY = 2'd0,
    TBL_MID    = 2'd1,
    TBL_DEEP   = 2'd2,
    TBL_PROG   = 2'd3
  } tbl_e;

  function automatic logic [7:0] fixed_rx_level(tbl_e tbl, logic [1:0] code);
    logic [7:0] v;
    unique case (tbl)
      TBL_LEGACY: v = (code == 2'd0) ? 8'd1 : (code == 2'd1) ? 8'd4 :
                      (code == 2'd2) ? 8'd8 : 8'd14;
      TBL_MID:    v = (code == 2'd0) ? 8'd8 : (code == 2'd1) ? 8'd16 :
                      (code == 2'd2) ? 8'd24 : 8'd28;
      TBL_DEEP:   v = (code == 2'd0) ? 8'd8 : (code == 2'd1) ? 8'd16 :
                      (code == 2'd2) ? 8'd56 : 8'd60;
      default:    v = 8'd1;
    endcase
    return v;
  endfunction

  function automatic logic [7:0] fixed_tx_level(tbl_e tbl, logic [1:0] code);
    logic [7:0] v;
    unique case (tbl)
      TBL_LEGACY: v = 8'd1;
      TBL_MID:    v = (code == 2'd0) ? 8'd16 : (code == 2'd1) ? 8'd8 :
                      (code == 2'd2) ? 8'd24 : 8'd30;
      TBL_DEEP:   v = (code == 2'd0) ? 8'd8 : (code == 2'd1) ? 8'd16 :
                      (code == 2'd2) ? 8'd32 : 8'd56;
      default:    v = 8'd1;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/trig_regs.sv
module trig_regs
  import uart_trig_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [7:0]       wr_data,
  output logic [1:0]       rx_code,
  output logic [1:0]       tx_code,
  output logic             dma_bit,
  output tbl_e             tbl_sel,
  output logic             unlock,
  output logic [CNT_W-1:0] rx_prog,
  output logic [CNT_W-1:0] tx_prog
);

  logic             prog_to_tx;
  logic [CNT_W-1:0] prog_val;

  always_comb begin
    if (wr_data == 8'd0)
      prog_val = CNT_W'(1);
    else if (int'(wr_data) > DEPTH)
      prog_val = CNT_W'(DEPTH);
    else
      prog_val = CNT_W'(wr_data);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_code    <= '0;
      tx_code    <= '0;
      dma_bit    <= 1'b0;
      tbl_sel    <= TBL_LEGACY;
      prog_to_tx <= 1'b0;
      unlock     <= 1'b0;
      rx_prog    <= CNT_W'(1);
      tx_prog    <= CNT_W'(1);
    end else if (wr_en) begin
      unique case (reg_sel_e'(wr_sel))
        SEL_FIFO_CTRL: begin
          rx_code <= wr_data[7:6];
          dma_bit <= wr_data[3];
          if (unlock) tx_code <= wr_data[5:4];
        end
        SEL_FEATURE: begin
          tbl_sel    <= tbl_e'(wr_data[5:4]);
          prog_to_tx <= wr_data[7];
        end
        SEL_UNLOCK: unlock <= wr_data[4];
        SEL_TRIGGER: begin
          if (prog_to_tx) tx_prog <= prog_val;
          else            rx_prog <= prog_val;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/trig_lookup.sv
module trig_lookup
  import uart_trig_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  tbl_e             tbl_sel,
  input  logic [1:0]       rx_code,
  input  logic [1:0]       tx_code,
  input  logic [CNT_W-1:0] rx_prog,
  input  logic [CNT_W-1:0] tx_prog,
  output logic [CNT_W-1:0] rx_lvl,
  output logic [CNT_W-1:0] tx_lvl
);

  logic [1:0][CNT_W-1:0] lvl;
  logic [1:0][1:0]       code;
  logic [1:0][CNT_W-1:0] prog;

  assign code = {tx_code, rx_code};
  assign prog = {tx_prog, rx_prog};

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic [7:0] fixed;
    if (d == 0) begin : g_rx
      assign fixed = fixed_rx_level(tbl_sel, code[d]);
    end else begin : g_tx
      assign fixed = fixed_tx_level(tbl_sel, code[d]);
    end
    assign lvl[d] = (tbl_sel == TBL_PROG) ? prog[d] : CNT_W'(fixed);
  end

  assign rx_lvl = lvl[0];
  assign tx_lvl = lvl[1];

endmodule

// File: rtl/tx_irq_ctrl.sv
module tx_irq_ctrl #(
  parameter int DEPTH = 128,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] tx_lvl,
  input  logic             tx_load,
  input  logic             tx_ack,
  output logic             tx_irq
);

  logic overfilled;
  logic cond;
  logic cond_q;

  assign cond = overfilled ? (tx_count < tx_lvl) : (tx_count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      overfilled <= 1'b0;
      cond_q     <= 1'b1;
      tx_irq     <= 1'b0;
    end else begin
      cond_q <= cond;
      if (tx_count == '0)
        overfilled <= 1'b0;
      else if (tx_count > tx_lvl)
        overfilled <= 1'b1;
      if (tx_load || tx_ack)
        tx_irq <= 1'b0;
      else if (cond && !cond_q)
        tx_irq <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_fifo_trig_ctrl.sv
module uart_fifo_trig_ctrl
  import uart_trig_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [7:0]       wr_data,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             tx_load,
  input  logic             tx_ack,
  output logic [CNT_W-1:0] rx_level,
  output logic [CNT_W-1:0] tx_level,
  output logic             rx_irq,
  output logic             tx_irq,
  output logic             dma_mode
);

  logic [1:0]       rx_code;
  logic [1:0]       tx_code;
  tbl_e             tbl_sel;
  logic             unlock;
  logic [CNT_W-1:0] rx_prog;
  logic [CNT_W-1:0] tx_prog;
  logic [CNT_W-1:0] rx_lvl_cur;
  logic [CNT_W-1:0] tx_lvl_cur;

  trig_regs #(.DEPTH(DEPTH)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rx_code(rx_code), .tx_code(tx_code), .dma_bit(dma_mode),
    .tbl_sel(tbl_sel), .unlock(unlock), .rx_prog(rx_prog), .tx_prog(tx_prog)
  );

  trig_lookup #(.DEPTH(DEPTH)) i_lookup (
    .tbl_sel(tbl_sel), .rx_code(rx_code), .tx_code(tx_code),
    .rx_prog(rx_prog), .tx_prog(tx_prog),
    .rx_lvl(rx_lvl_cur), .tx_lvl(tx_lvl_cur)
  );

  tx_irq_ctrl #(.DEPTH(DEPTH)) i_txirq (
    .clk(clk), .rst(rst), .tx_count(tx_count), .tx_lvl(tx_lvl_cur),
    .tx_load(tx_load), .tx_ack(tx_ack), .tx_irq(tx_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_level <= CNT_W'(1);
      tx_level <= CNT_W'(1);
      rx_irq   <= 1'b0;
    end else begin
      rx_level <= rx_lvl_cur;
      tx_level <= tx_lvl_cur;
      rx_irq   <= (rx_count >= rx_lvl_cur);
    end
  end

endmodule

// File: rtl/uart_fifo_trig_chk.sv
module uart_fifo_trig_chk #(
  parameter int DEPTH = 128,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [7:0]       wr_data,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] tx_count,
  input logic             tx_load,
  input logic             tx_ack,
  input logic [CNT_W-1:0] rx_level,
  input logic [CNT_W-1:0] tx_level,
  input logic             rx_irq,
  input logic             tx_irq,
  input logic             dma_mode,
  input logic             unlock,
  input logic [1:0]       tx_code,
  input logic [CNT_W-1:0] rx_lvl_cur,
  input logic [CNT_W-1:0] tx_lvl_cur
);

  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  a_r8_rx_irq_follows: assert property (@(posedge clk) disable iff (rst || !seen)
    rx_irq == ($past(rx_count) >= $past(rx_lvl_cur)));

  a_r11_tx_clear: assert property (@(posedge clk) disable iff (rst)
    (tx_ack || tx_load) |=> !tx_irq);

  a_r12_dma_store: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0) |=> (dma_mode == $past(wr_data[3])));

  a_r7_tx_code_locked: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0 && !unlock) |=> $stable(tx_code));

  a_r10_tx_set_cause: assert property (@(posedge clk) disable iff (rst || !seen)
    $rose(tx_irq) |-> ($past(tx_count) < $past(tx_lvl_cur)));

  a_r13_level_range: assert property (@(posedge clk) disable iff (rst)
    (rx_level >= CNT_W'(1)) && (int'(rx_level) <= DEPTH) &&
    (tx_level >= CNT_W'(1)) && (int'(tx_level) <= DEPTH));

endmodule

bind uart_fifo_trig_ctrl uart_fifo_trig_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .rx_count(rx_count), .tx_count(tx_count), .tx_load(tx_load), .tx_ack(tx_ack),
  .rx_level(rx_level), .tx_level(tx_level), .rx_irq(rx_irq), .tx_irq(tx_irq),
  .dma_mode(dma_mode), .unlock(unlock), .tx_code(tx_code),
  .rx_lvl_cur(rx_lvl_cur), .tx_lvl_cur(tx_lvl_cur)
);

// File: tb/test_uart_fifo_trig_ctrl.sv
module test_uart_fifo_trig_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_sel = '0;
  logic [7:0]       wr_data = '0;
  logic [CNT_W-1:0] rx_count = '0;
  logic [CNT_W-1:0] tx_count = '0;
  logic             tx_load = 1'b0;
  logic             tx_ack = 1'b0;
  logic [CNT_W-1:0] rx_level;
  logic [CNT_W-1:0] tx_level;
  logic             rx_irq;
  logic             tx_irq;
  logic             dma_mode;

  int n_checks = 0;
  int n_fail = 0;
  string cur_tag = "R1";

  uart_fifo_trig_ctrl #(.DEPTH(DEPTH)) i_uart_fifo_trig_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rx_count(rx_count), .tx_count(tx_count), .tx_load(tx_load), .tx_ack(tx_ack),
    .rx_level(rx_level), .tx_level(tx_level), .rx_irq(rx_irq), .tx_irq(tx_irq),
    .dma_mode(dma_mode)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // reference model state
  int m_rxc, m_txc, m_tbl, m_dir, m_unl, m_rxp, m_txp, m_dma;
  int m_rxl, m_txl, m_rxirq, m_over, m_condq, m_irq;

  function automatic int ref_level(int tbl, int code, int prog, bit is_tx);
    int a_rx[4] = '{1, 4, 8, 14};
    int b_rx[4] = '{8, 16, 24, 28};
    int b_tx[4] = '{16, 8, 24, 30};
    int c_rx[4] = '{8, 16, 56, 60};
    int c_tx[4] = '{8, 16, 32, 56};
    if (tbl == 3) return prog;
    if (tbl == 0) return is_tx ? 1 : a_rx[code];
    if (tbl == 1) return is_tx ? b_tx[code] : b_rx[code];
    return is_tx ? c_tx[code] : c_rx[code];
  endfunction

  function automatic int ref_clamp(int v);
    if (v == 0) return 1;
    if (v > DEPTH) return DEPTH;
    return v;
  endfunction

  task automatic model_reset();
    m_rxc = 0; m_txc = 0; m_tbl = 0; m_dir = 0; m_unl = 0;
    m_rxp = 1; m_txp = 1; m_dma = 0;
    m_rxl = 1; m_txl = 1; m_rxirq = 0; m_over = 0; m_condq = 1; m_irq = 0;
  endtask

  task automatic check(string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    check("rx_level", int'(rx_level), m_rxl);
    check("tx_level", int'(tx_level), m_txl);
    check("rx_irq", int'(rx_irq), m_rxirq);
    check("tx_irq", int'(tx_irq), m_irq);
    check("dma_mode", int'(dma_mode), m_dma);
  endtask

  // one clock with current inputs; model advanced, outputs compared at negedge
  task automatic cyc();
    int rlc, tlc, rxcnt, txcnt, cond;
    int n_irq, n_over;
    rxcnt = int'(rx_count);
    txcnt = int'(tx_count);
    rlc = ref_level(m_tbl, m_rxs, m_rxp, 1'b0);
    tlc = ref_level(m_tbl, m_txs, m_txp, 1'b1);
    cond = m_over ? int'(txcnt < tlc) : int'(txcnt == 0);
    if (tx_load || tx_ack) n_irq = 0;
    else if (cond != 0 && m_condq == 0) n_irq = 1;
    else n_irq = m_irq;
    if (txcnt == 0) n_over = 0;
    else if (txcnt > tlc) n_over = 1;
    else n_over = m_over;
    if (wr_en) begin
      case (wr_sel)
        2'd0: begin
          m_rxs = int'(wr_data[7:6]);
          m_dma = int'(wr_data[3]);
          if (m_unl != 0) m_txs = int'(wr_data[5:4]);
        end
        2'd1: begin m_tbl = int'(wr_data[5:4]); m_dir = int'(wr_data[7]); end
        2'd2: m_unl = int'(wr_data[4]);
        default: begin
          if (m_dir != 0) m_txp = ref_clamp(int'(wr_data));
          else            m_rxp = ref_clamp(int'(wr_data));
        end
      endcase
    end
    m_rxl = rlc; m_txl = tlc; m_rxirq = int'(rxcnt >= rlc);
    m_condq = cond; m_irq = n_irq; m_over = n_over;
    @(posedge clk);
    @(negedge clk);
    check_all();
    wr_en = 1'b0; tx_load = 1'b0; tx_ack = 1'b0;
  endtask

  int m_rxs, m_txs;

  task automatic wr(int sel, int data);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 8'(data);
    cyc();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    model_reset(); m_rxs = 0; m_txs = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cur_tag = "R1"; check_all();
    idle(2);

    // R2: legacy table, rx codes
    cur_tag = "R2";
    for (int c = 0; c < 4; c++) begin wr(0, c << 6); idle(2); end

    // R7: tx code locked while unlock clear
    cur_tag = "R7";
    wr(1, 8'h10); wr(0, 8'h30); idle(2);
    wr(2, 8'h10);
    // R3: mid table with unlock
    cur_tag = "R3";
    for (int c = 0; c < 4; c++) begin wr(0, (c << 6) | (c << 4)); idle(2); end
    cur_tag = "R4";
    wr(1, 8'h20);
    for (int c = 0; c < 4; c++) begin wr(0, (c << 6) | ((3 - c) << 4)); idle(2); end
    cur_tag = "R7";
    wr(2, 8'h00); wr(0, 8'h00); idle(2);

    // R5/R6: programmable levels
    cur_tag = "R5";
    wr(1, 8'h30); wr(3, 40); wr(1, 8'hB0); wr(3, 20); idle(2);
    cur_tag = "R6";
    wr(3, 0); idle(2); wr(3, 200); idle(2); wr(1, 8'h30); wr(3, 128); idle(2);
    wr(3, 0); idle(2);

    // R12: dma bit
    cur_tag = "R12";
    wr(0, 8'h08); idle(1); wr(0, 8'h00); idle(1);

    // R8: rx interrupt at level 14 (legacy code 3)
    cur_tag = "R8";
    wr(1, 8'h00); wr(0, 8'hC0); idle(2);
    rx_count = 13; idle(2); rx_count = 14; idle(2); rx_count = 60; idle(1);
    rx_count = 13; idle(2); rx_count = 0;

    // R9: mid table tx code 0 -> 16; overfill then drop below
    cur_tag = "R9";
    wr(2, 8'h10); wr(1, 8'h10); wr(0, 8'h00); idle(2);
    tx_count = 20; idle(2); tx_count = 16; idle(2); tx_count = 15; idle(2);
    cur_tag = "R11";
    tx_ack = 1'b1; idle(2);
    tx_count = 5; tx_load = 1'b1; idle(1);
    // R10: never above trigger -> empty rule
    cur_tag = "R10";
    tx_count = 10; idle(2); tx_count = 3; idle(2); tx_count = 0; idle(3);
    cur_tag = "R11";
    tx_count = 1; tx_load = 1'b1; idle(1); tx_count = 0; idle(1);
    tx_ack = 1'b1; idle(2);

    // random phase
    cur_tag = "R8/R9/R10/R11 random";
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 20) begin
        wr_en = 1'b1;
        wr_sel = 2'($urandom_range(0, 3));
        wr_data = 8'($urandom_range(0, 255));
      end
      if ($urandom_range(0, 3) == 0) rx_count = CNT_W'($urandom_range(0, DEPTH));
      r = int'($urandom_range(0, 9));
      if (r < 3) begin
        int t;
        t = int'(tx_count) + int'($urandom_range(0, 40)) - 20;
        if (t < 0) t = 0;
        if (t > DEPTH) t = DEPTH;
        tx_count = CNT_W'(t);
        tx_load = ($urandom_range(0, 1) == 1);
      end else if (r == 3) begin
        tx_count = '0;
      end
      tx_ack = ($urandom_range(0, 15) == 0);
      cyc();
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule